// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This unit settles which NaN a three-operand multiply-add (a*b)+c hands back once at least one operand is a NaN. The upstream datapath has already classified each operand as quiet or signaling and has flagged whether the product was infinity times zero. The unit also needs a default-NaN mode bit and a two-bit style select. From these it picks one operand or the default NaN. It quiets the chosen operand and raises the invalid flag where the chosen style requires it.

Four priority styles are available. Each style has its own rule for the infinity-times-zero product. Default-NaN mode is applied only after a choice has been made. As a result, the invalid flag and the reported pick code are the same with the mode on or off, and only the value is overridden. The result, flag and code are registered. They appear one cycle after a valid input, together with an output valid.

Top module: `fma_nan_pick`

## Requirements
- R1: While reset is asserted, and after it is released with no valid input yet seen, out_valid, result, invalid and pick are all zero.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. When in_valid is low, result, invalid and pick keep their previous values.
- R3: A signaling flag on any of the three operands sets invalid for that input.
- R4: With style 1, if inf_zero is set and c is a quiet NaN, then pick is 3 and invalid is set. If inf_zero is set and c is signaling, the normal order applies.
- R5: With style 1, the order is c signaling, then a signaling, then b signaling, then c quiet, then a quiet, and otherwise b.
- R6: With style 2, a set inf_zero gives pick 3 with invalid set. Otherwise the order is a signaling, b signaling, c signaling, a quiet, b quiet, and otherwise c.
- R7: With style 3, a set inf_zero gives pick 2 with invalid set. Otherwise the order is a if it is any NaN, then c if it is any NaN, and otherwise b.
- R8: With style 0, the order is a if it is any NaN, then b if it is any NaN, and otherwise c. inf_zero alone does not set invalid.
- R9: Pick codes are 0 for a, 1 for b, 2 for c and 3 for the default NaN. For picks 0 to 2 with the mode off, result is the chosen operand with its top fraction bit (bit FRAC_W-1) set and every other bit unchanged.
- R10: With dflt_mode set, result is the default NaN, while pick and invalid are the same as with the mode clear.
- R11: The default NaN has sign 0, all exponent bits set and only the top fraction bit set (0x7FC00000 at the default widths). It is the result whenever pick is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| op_a | input | W | Multiplicand a |
| op_b | input | W | Multiplier b |
| op_c | input | W | Addend c |
| a_quiet | input | 1 | a is a quiet NaN |
| a_signal | input | 1 | a is a signaling NaN |
| b_quiet | input | 1 | b is a quiet NaN |
| b_signal | input | 1 | b is a signaling NaN |
| c_quiet | input | 1 | c is a quiet NaN |
| c_signal | input | 1 | c is a signaling NaN |
| inf_zero | input | 1 | Product was infinity times zero |
| dflt_mode | input | 1 | Force default NaN on the result |
| style | input | 2 | Priority style: 0 plain, 1, 2, 3 |
| out_valid | output | 1 | Registered outputs updated |
| result | output | W | Chosen NaN |
| invalid | output | 1 | Invalid-operation flag |
| pick | output | 2 | Selection code |

## Verification
The assertions take for granted that each operand has at most one of its quiet and signaling flags set. They also assume that inf_zero is only raised when c is flagged as a NaN, since the unit is only consulted when some operand is a NaN. Every stimulus vector obeys both rules, and each one carries at least one NaN flag. Operand values are chosen with distinct payloads and a set sign on c. That makes a wrong pick or a stray sign bit visible on the result.

// File: rtl/fma_nan_pick.sv
module fma_nan_pick #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic         a_quiet,
  input  logic         a_signal,
  input  logic         b_quiet,
  input  logic         b_signal,
  input  logic         c_quiet,
  input  logic         c_signal,
  input  logic         inf_zero,
  input  logic         dflt_mode,
  input  logic [1:0]   style,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         invalid,
  output logic [1:0]   pick
);
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DNAN = ({{(EXP_W){1'b1}}, {(FRAC_W){1'b0}}}) | QBIT;

  logic       a_nan, b_nan, c_nan;
  logic [1:0] pick_n;
  logic       iz_inv;
  logic [W-1:0] chosen, res_n;

  assign a_nan = a_quiet | a_signal;
  assign b_nan = b_quiet | b_signal;
  assign c_nan = c_quiet | c_signal;

  always_comb begin
    iz_inv = 1'b0;
    pick_n = 2'd2;
    case (style)
      2'd1: begin
        if (inf_zero && c_quiet) begin
          iz_inv = 1'b1;
          pick_n = 2'd3;
        end
        else if (c_signal) pick_n = 2'd2;
        else if (a_signal) pick_n = 2'd0;
        else if (b_signal) pick_n = 2'd1;
        else if (c_quiet)  pick_n = 2'd2;
        else if (a_quiet)  pick_n = 2'd0;
        else               pick_n = 2'd1;
      end
      2'd2: begin
        if (inf_zero) begin
          iz_inv = 1'b1;
          pick_n = 2'd3;
        end
        else if (a_signal) pick_n = 2'd0;
        else if (b_signal) pick_n = 2'd1;
        else if (c_signal) pick_n = 2'd2;
        else if (a_quiet)  pick_n = 2'd0;
        else if (b_quiet)  pick_n = 2'd1;
        else               pick_n = 2'd2;
      end
      2'd3: begin
        if (inf_zero) begin
          iz_inv = 1'b1;
          pick_n = 2'd2;
        end
        else if (a_nan) pick_n = 2'd0;
        else if (c_nan) pick_n = 2'd2;
        else            pick_n = 2'd1;
      end
      default: begin
        if (a_nan)      pick_n = 2'd0;
        else if (b_nan) pick_n = 2'd1;
        else            pick_n = 2'd2;
      end
    endcase
  end

  always_comb begin
    case (pick_n)
      2'd0:    chosen = op_a;
      2'd1:    chosen = op_b;
      default: chosen = op_c;
    endcase
  end

  assign res_n = (dflt_mode || pick_n == 2'd3) ? DNAN : (chosen | QBIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
      pick      <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_n;
        invalid <= a_signal | b_signal | c_signal | iz_inv;
        pick    <= pick_n;
      end
    end
  end
endmodule

// File: rtl/fma_nan_pick_chk.sv
module fma_nan_pick_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic         a_quiet,
  input logic         a_signal,
  input logic         b_signal,
  input logic         c_signal,
  input logic         inf_zero,
  input logic         dflt_mode,
  input logic [1:0]   style,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         invalid,
  input logic [1:0]   pick
);
  localparam logic [W-1:0] QB = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DN = ({{(EXP_W){1'b1}}, {(FRAC_W){1'b0}}}) | QB;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid) && $stable(pick)));
  // R3
  snan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_signal || b_signal || c_signal)) |=> invalid);
  // R6
  styleb_iz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && style == 2'd2 && inf_zero) |=> (pick == 2'd3 && invalid));
  // R7
  stylec_iz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && style == 2'd3 && inf_zero) |=> (pick == 2'd2 && invalid));
  // R9
  quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && style == 2'd0 && !dflt_mode && (a_quiet || a_signal))
      |=> (pick == 2'd0 && result == ($past(op_a) | QB)));
  // R10
  dflt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dflt_mode) |=> result == DN);
  // R11
  code3_dnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pick == 2'd3) |-> result == DN);
endmodule

bind fma_nan_pick fma_nan_pick_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
  .a_quiet(a_quiet), .a_signal(a_signal), .b_signal(b_signal),
  .c_signal(c_signal), .inf_zero(inf_zero), .dflt_mode(dflt_mode),
  .style(style), .out_valid(out_valid), .result(result),
  .invalid(invalid), .pick(pick)
);

// File: tb/fma_nan_pick_bench.sv
module fma_nan_pick_bench;
  localparam int W = 32;
  localparam logic [31:0] DNAN = 32'h7FC0_0000;
  localparam logic [31:0] QB   = 32'h0040_0000;
  localparam logic [31:0] VA   = 32'h7F80_0011;
  localparam logic [31:0] VB   = 32'h7F80_0022;
  localparam logic [31:0] VC   = 32'hFF80_0033;
  localparam int NV = 27;

  // {style, aq,as,bq,bs,cq,cs, inf_zero, dflt_mode, exp_pick, exp_invalid}
  localparam logic [12:0] VEC [NV] = '{
    {2'd1, 6'b000010, 1'b1, 1'b0, 2'd3, 1'b1},  // R4
    {2'd1, 6'b000001, 1'b1, 1'b0, 2'd2, 1'b1},  // R4 signaling c
    {2'd1, 6'b010001, 1'b0, 1'b0, 2'd2, 1'b1},  // R5
    {2'd1, 6'b010100, 1'b0, 1'b0, 2'd0, 1'b1},  // R5
    {2'd1, 6'b000110, 1'b0, 1'b0, 2'd1, 1'b1},  // R5
    {2'd1, 6'b100010, 1'b0, 1'b0, 2'd2, 1'b0},  // R5
    {2'd1, 6'b101000, 1'b0, 1'b0, 2'd0, 1'b0},  // R5
    {2'd1, 6'b001000, 1'b0, 1'b0, 2'd1, 1'b0},  // R5
    {2'd2, 6'b000010, 1'b1, 1'b0, 2'd3, 1'b1},  // R6
    {2'd2, 6'b100001, 1'b1, 1'b0, 2'd3, 1'b1},  // R6
    {2'd2, 6'b100001, 1'b0, 1'b0, 2'd2, 1'b1},  // R6
    {2'd2, 6'b010100, 1'b0, 1'b0, 2'd0, 1'b1},  // R6
    {2'd2, 6'b100100, 1'b0, 1'b0, 2'd1, 1'b1},  // R6
    {2'd2, 6'b101000, 1'b0, 1'b0, 2'd0, 1'b0},  // R6
    {2'd2, 6'b001010, 1'b0, 1'b0, 2'd1, 1'b0},  // R6
    {2'd2, 6'b000010, 1'b0, 1'b0, 2'd2, 1'b0},  // R6
    {2'd3, 6'b100010, 1'b1, 1'b0, 2'd2, 1'b1},  // R7
    {2'd3, 6'b100001, 1'b0, 1'b0, 2'd0, 1'b1},  // R7
    {2'd3, 6'b000110, 1'b0, 1'b0, 2'd2, 1'b1},  // R7
    {2'd3, 6'b001000, 1'b0, 1'b0, 2'd1, 1'b0},  // R7
    {2'd0, 6'b100100, 1'b0, 1'b0, 2'd0, 1'b1},  // R8
    {2'd0, 6'b001001, 1'b0, 1'b0, 2'd1, 1'b1},  // R8
    {2'd0, 6'b000010, 1'b1, 1'b0, 2'd2, 1'b0},  // R8
    {2'd0, 6'b000001, 1'b0, 1'b0, 2'd2, 1'b1},  // R8 / R3
    {2'd1, 6'b100100, 1'b0, 1'b1, 2'd1, 1'b1},  // R10
    {2'd2, 6'b000010, 1'b1, 1'b1, 2'd3, 1'b1},  // R10 / R11
    {2'd3, 6'b001000, 1'b0, 1'b1, 2'd1, 1'b0}   // R10
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] op_a = VA, op_b = VB, op_c = VC;
  logic a_quiet = 0, a_signal = 0, b_quiet = 0, b_signal = 0, c_quiet = 0, c_signal = 0;
  logic inf_zero = 0, dflt_mode = 0;
  logic [1:0] style = 2'd0;
  logic out_valid, invalid;
  logic [W-1:0] result;
  logic [1:0] pick;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fma_nan_pick u_fma_nan_pick (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .a_quiet(a_quiet), .a_signal(a_signal), .b_quiet(b_quiet),
    .b_signal(b_signal), .c_quiet(c_quiet), .c_signal(c_signal),
    .inf_zero(inf_zero), .dflt_mode(dflt_mode), .style(style),
    .out_valid(out_valid), .result(result), .invalid(invalid), .pick(pick)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [12:0] v);
    if (v[4]) return "R10";
    case (v[12:11])
      2'd1: return v[4+1] ? "R4" : "R5";
      2'd2: return "R6";
      2'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "result", result, 32'd0);
    check("R1", "invalid", {31'd0, invalid}, 32'd0);
    check("R1", "pick", {30'd0, pick}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after release", {31'd0, out_valid}, 32'd0);
    check("R1", "result after release", result, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      logic [31:0] exp_res;
      v = VEC[i];
      style = v[12:11];
      {a_quiet, a_signal, b_quiet, b_signal, c_quiet, c_signal} = v[10:5];
      inf_zero = v[4+1-1+1-1+0] ;
      inf_zero = v[4];
      dflt_mode = v[3];
      in_valid = 1'b1;
      @(negedge clk);
      if (v[3] || v[2:1] == 2'd3) exp_res = DNAN;
      else if (v[2:1] == 2'd0) exp_res = VA | QB;
      else if (v[2:1] == 2'd1) exp_res = VB | QB;
      else exp_res = VC | QB;
      check(tag_of(v), "pick", {30'd0, pick}, {30'd0, v[2:1]});
      check(v[10:5] & 6'b010101 ? "R3" : tag_of(v), "invalid", {31'd0, invalid}, {31'd0, v[0]});
      check(v[3] ? "R10" : "R9", "result", result, exp_res);
      check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
    end

    // R2: idle cycle holds values, out_valid drops
    in_valid = 1'b0;
    style = 2'd0; {a_quiet, a_signal, b_quiet, b_signal, c_quiet, c_signal} = 6'b100000;
    inf_zero = 1'b0; dflt_mode = 1'b0;
    @(negedge clk);
    check("R2", "out_valid idle", {31'd0, out_valid}, 32'd0);
    check("R2", "pick held", {30'd0, pick}, 32'd1);
    check("R2", "result held", result, DNAN);

    // R9: payload and sign preserved, only top fraction bit added
    op_a = 32'hFF80_1234;
    in_valid = 1'b1; a_quiet = 1'b0; a_signal = 1'b1;
    @(negedge clk);
    check("R9", "quieted a", result, 32'hFFC0_1234);
    check("R3", "invalid plain snan", {31'd0, invalid}, 32'd1);

    // R11: style 1 default NaN pattern
    style = 2'd1; a_signal = 1'b0; c_quiet = 1'b1; inf_zero = 1'b1;
    @(negedge clk);
    check("R11", "default NaN", result, DNAN);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule